// File: doc/BRIEF.md
# Alarm Code Register and Buzzer Window

This block keeps one alarm setting and watches the running time of a 12-hour clock. A load strobe writes an alarm code into the register. When the live time code becomes equal to the stored code, the block raises its buzzer output. The output then stays high for a window of 60 one-second ticks. Tone generation, keypad decoding and the time counters are outside this block. The block takes the live time as a packed slice and the 1 Hz tick as a single-cycle enable. Both come from the counter chain, in the same clock domain.

The code is 17 bits wide:
- bit 16 is the PM flag (1 = PM).
- bits 15:8 are the hour as two BCD digits, from 01 to 12.
- bits 7:0 are the minute as two BCD digits, from 00 to 59.

Seconds play no part. A cleared register holds all zeros. That value is never taken as a match, so an alarm that was never set stays quiet. A disable input silences an alarm that is sounding and keeps a new one from starting. Only the moment the time enters a match starts an alarm. A minute that keeps on matching after the window ends, or after a disable, does not start it again.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, `buzz_o` is 0 and the stored code is all zeros.
- R2: A cycle with `load_i` high and `clear_i` low stores `code_i`. From the next cycle on, the stored code is the one compared against `time_i`.
- R3: A cycle with `clear_i` high sets the stored code to all zeros. This holds even when `load_i` is high in the same cycle. After that, the previously loaded time no longer sounds the alarm.
- R4: When `time_i` becomes equal to a non-zero stored code, `buzz_o` goes to 1 after exactly one clock edge.
- R5: Once started, `buzz_o` stays 1 until the 60th cycle with `tick_1hz_i` high. It falls after that clock edge. Cycles without a tick do not shorten the window, and ticks while idle start nothing.
- R6: While the match holds without a break, the alarm does not restart. Leaving the match and entering it again starts a new window.
- R7: `disable_i` high drops `buzz_o` to 0 after the next clock edge. While `disable_i` is high, a new match does not start the alarm.
- R8: A load during a window ends the window. `buzz_o` is 0 after that edge.
- R9: An all-zero stored code never matches, not even an all-zero `time_i`.
- R10: A match requires all 17 bits to be equal. A code that differs only in the PM bit (bit 16) does not sound the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1hz_i | input | 1 | One-cycle enable, once per second |
| load_i | input | 1 | Store `code_i` as the alarm setting |
| clear_i | input | 1 | Zero the alarm setting (wins over load) |
| code_i | input | 17 | Alarm code to store: PM flag, BCD hour, BCD minute |
| time_i | input | 17 | Live time code in the same layout |
| disable_i | input | 1 | Stop a sounding alarm and block new ones |
| buzz_o | output | 1 | Buzzer enable, high during the alarm window |

## Verification
The assertions assume every input is synchronous to `clk_i`. They also assume `tick_1hz_i` is a one-cycle pulse, and that `time_i` changes only between edges. A reachable live time is never all zeros.

The bench drives every input on the falling edge and samples `buzz_o` on the following falling edge. It uses only valid BCD time codes. The one exception is the all-zero code, which is applied on purpose to show that it never matches. Ticks are always separated by at least one idle cycle, as a real 1 Hz enable would be.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned CODE_W       = 17;
  localparam int unsigned WINDOW_TICKS = 60;
endpackage

// File: rtl/alarm_code_reg.sv
module alarm_code_reg #(
  parameter int unsigned CODE_W = alarm_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] alarm_o
);
  logic [CODE_W-1:0] alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      alarm_q <= '0;
    else if (clear_i) alarm_q <= '0;
    else if (load_i)  alarm_q <= code_i;
  end

  assign alarm_o = alarm_q;

  // R3
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (alarm_o == '0));

  // R2
  load_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> (alarm_o == $past(code_i)));
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int unsigned CODE_W = alarm_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] alarm_i,
  input  logic [CODE_W-1:0] time_i,
  output logic              rise_o
);
  logic [CODE_W-1:0] bit_eq;
  logic              armed;
  logic              eq_c;
  logic              eq_q;

  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    assign bit_eq[b] = ~(alarm_i[b] ^ time_i[b]);
  end

  // all-zero setting means "not set"
  assign armed = |alarm_i;
  assign eq_c  = armed & (&bit_eq);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq_c;
  end

  assign rise_o = eq_c & ~eq_q;

  // R9
  zero_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_i == '0) |-> !rise_o);

  // R6
  no_double_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/alarm_window.sv
module alarm_window #(
  parameter int unsigned WINDOW_TICKS = alarm_pkg::WINDOW_TICKS,
  localparam int unsigned CNT_W       = $clog2(WINDOW_TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  input  logic tick_i,
  output logic active_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_TICKS - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cancel_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R7 R8
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !active_o);

  // R4
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !cancel_i) |=> (active_o && cnt_q == '0));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !tick_i && !cancel_i) |=> active_o);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int unsigned CODE_W       = alarm_pkg::CODE_W,
  parameter int unsigned WINDOW_TICKS = alarm_pkg::WINDOW_TICKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_1hz_i,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] time_i,
  input  logic              disable_i,
  output logic              buzz_o
);
  logic [CODE_W-1:0] alarm_code;
  logic              match_rise;
  logic              cancel;

  // a new setting, a cleared setting or a disable all end the window
  assign cancel = disable_i | load_i | clear_i;

  alarm_code_reg #(.CODE_W(CODE_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .clear_i (clear_i),
    .code_i  (code_i),
    .alarm_o (alarm_code)
  );

  alarm_cmp #(.CODE_W(CODE_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alarm_i (alarm_code),
    .time_i  (time_i),
    .rise_o  (match_rise)
  );

  alarm_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (match_rise),
    .cancel_i (cancel),
    .tick_i   (tick_1hz_i),
    .active_o (buzz_o)
  );

  // R7
  disable_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> !buzz_o);

  // R4
  buzz_needs_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buzz_o) |-> (alarm_code != '0));
endmodule

// File: tb/alarm_match_unit_bench.sv
module alarm_match_unit_bench;
  localparam int W = 17;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_1hz_i = 1'b0;
  logic         load_i = 1'b0;
  logic         clear_i = 1'b0;
  logic [W-1:0] code_i = '0;
  logic [W-1:0] time_i = '0;
  logic         disable_i = 1'b0;
  logic         buzz_o;

  int errors = 0;
  int checks = 0;

  localparam logic [W-1:0] T_A   = {1'b0, 8'h07, 8'h30};
  localparam logic [W-1:0] T_APM = {1'b1, 8'h07, 8'h30};
  localparam logic [W-1:0] T_B   = {1'b1, 8'h11, 8'h59};
  localparam logic [W-1:0] T_OFF = {1'b0, 8'h03, 8'h15};

  alarm_match_unit u_alarm_match_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_1hz_i(tick_1hz_i),
    .load_i(load_i), .clear_i(clear_i), .code_i(code_i),
    .time_i(time_i), .disable_i(disable_i), .buzz_o(buzz_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic exp);
    checks++;
    if (buzz_o !== exp) begin
      errors++;
      $display("FAIL %s: buzz_o=%b expected %b", req, buzz_o, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] c);
    code_i = c; load_i = 1'b1; step(); load_i = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_1hz_i = 1'b1; step(); tick_1hz_i = 1'b0; step();
    end
  endtask

  task automatic enter(input logic [W-1:0] t);
    time_i = T_OFF; step(); time_i = t; step();
  endtask

  task automatic t_reset;
    step(2);
    check("R1 reset", 1'b0);
    time_i = '0; step(2);
    check("R9 zero code vs zero time", 1'b0);
    ticks(3);
    check("R5 idle ticks", 1'b0);
  endtask

  task automatic t_fire_window;
    load(T_A);
    enter(T_A);
    check("R2 R4 fire on match", 1'b1);
    step(100);
    check("R5 no-tick cycles keep window", 1'b1);
    ticks(59);
    check("R5 high after 59 ticks", 1'b1);
    tick_1hz_i = 1'b1; step(); tick_1hz_i = 1'b0;
    check("R5 low after 60th tick", 1'b0);
    step(5); ticks(2);
    check("R6 no retrigger in same match", 1'b0);
    enter(T_A);
    check("R6 retrigger on re-entry", 1'b1);
  endtask

  task automatic t_disable;
    disable_i = 1'b1; step();
    check("R7 disable stops alarm", 1'b0);
    enter(T_A);
    check("R7 disable blocks start", 1'b0);
    disable_i = 1'b0; step(3);
    check("R7 R6 no start after release", 1'b0);
  endtask

  task automatic t_load_cancel;
    enter(T_A);
    check("R4 fire before cancel", 1'b1);
    load(T_B);
    check("R8 load cancels window", 1'b0);
    enter(T_A);
    check("R2 old code replaced", 1'b0);
    enter(T_B);
    check("R2 new code fires", 1'b1);
    disable_i = 1'b1; step(); disable_i = 1'b0;
  endtask

  task automatic t_ampm;
    load(T_APM);
    enter(T_A);
    check("R10 PM bit differs", 1'b0);
    enter(T_APM);
    check("R10 full match fires", 1'b1);
    disable_i = 1'b1; step(); disable_i = 1'b0;
  endtask

  task automatic t_clear;
    load(T_A);
    clear_i = 1'b1; step(); clear_i = 1'b0;
    enter(T_A);
    check("R3 cleared code silent", 1'b0);
    code_i = T_B; load_i = 1'b1; clear_i = 1'b1; step();
    load_i = 1'b0; clear_i = 1'b0;
    enter(T_B);
    check("R3 clear wins over load", 1'b0);
    time_i = '0; step(2);
    check("R9 cleared vs zero time", 1'b0);
  endtask

  initial begin
    step(2); rst_ni = 1'b1;
    t_reset();
    t_fire_window();
    t_disable();
    t_load_cancel();
    t_ampm();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule